// File: doc/BRIEF.md
# Interrupt Request Priority and In-Service Core

This block tracks requests and picks a winner for an eight-input interrupt controller. Each request line is edge-detected. A rising edge latches a pending bit in the request register. The pending bits are gated by an external mask, and an interrupt output is raised whenever any unmasked request is pending.

When the processor acknowledges, the block chooses the highest-priority eligible request. Input 0 ranks highest. The winner leaves the request register and enters the in-service register. In the same clock, a vector equal to the winner's input number plus a programmable base is captured.

Software retires in-service entries with end-of-interrupt commands. A specific command clears the entry named by a 3-bit level. A non-specific command clears the highest-priority entry that is set. Every other command code is ignored.

Top module: `irq_prio_core`

## Requirements
- R1: A rising edge on `req_i[i]` sets `irr_o[i]` after the next clock edge. A line held high sets the bit only once, so after an acknowledge clears it the bit stays clear until the line falls and rises again.
- R2: `irq_o` is high in the same cycle whenever `irr_o & ~mask_i` is non-zero, and low otherwise. A mask bit set to 1 blocks its input.
- R3: The eligible winner is the lowest-numbered unmasked pending input `p` for which no `isr_o` bit at index `p` or below is set.
- R4: An acknowledge with an eligible winner `p` does three things at the next clock edge. It clears `irr_o[p]`, sets `isr_o[p]`, and loads `vec_o` with `vec_base_i + p` (modulo 256).
- R5: A strobe with `eoi_cmd_i = 3'b101` (bit 2 = end, bit 1 = rotate, bit 0 = select level) is a specific end-of-interrupt. It clears `isr_o[eoi_level_i]`.
- R6: A strobe with `eoi_cmd_i = 3'b100` is a non-specific end-of-interrupt. It clears only the lowest-numbered set bit of `isr_o`.
- R7: A strobe carrying any other `eoi_cmd_i` value leaves `isr_o` unchanged.
- R8: `vec_o` changes only on an acknowledge that has an eligible winner. An acknowledge without one leaves `vec_o`, `irr_o` and `isr_o` unchanged.
- R9: During reset `irr_o`, `isr_o` and `vec_o` are zero, and `irq_o` is low.
- R10: When an acknowledge and an end-of-interrupt fall in the same cycle, the end-of-interrupt clear is taken from the old in-service value and the acknowledged bit is then set. When an acknowledge clears a request bit in the same cycle that its line has a new rising edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_IRQ | Request lines, edge-detected |
| mask_i | input | N_IRQ | Mask, 1 blocks the input |
| vec_base_i | input | VEC_W | Base added to the winner index |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_stb_i | input | 1 | End-of-interrupt command strobe |
| eoi_cmd_i | input | 3 | Command flags {end, rotate, select level} |
| eoi_level_i | input | LVL_W | Level for a specific end-of-interrupt |
| irq_o | output | 1 | Unmasked request pending |
| vec_o | output | VEC_W | Vector captured on the last successful acknowledge |
| irr_o | output | N_IRQ | Request register |
| isr_o | output | N_IRQ | In-service register |

## Verification
A corrupt request or in-service bit shows up one clock later on `irr_o` or `isr_o`. It also shows up on `irq_o` in the same cycle once the mask exposes it. A wrong priority decision stays hidden until the next acknowledge, when `vec_o` and the bit that moves into `isr_o` both disagree with the expected winner. A mishandled end-of-interrupt can also stay silent for a while. It appears when a lower-priority request that should have been unblocked fails to win its acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    // End-of-interrupt command encoding: {end, rotate, select level}
    localparam logic [2:0] EOI_CMD_SPECIFIC = 3'b101;
    localparam logic [2:0] EOI_CMD_LOWEST   = 3'b100;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  onehot_o
);
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                found_o  = 1'b1;
                idx_o    = IW'(i);
                onehot_o = W'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    localparam int LVL_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] req_i,
    input  logic [N_IRQ-1:0] mask_i,
    input  logic [VEC_W-1:0] vec_base_i,
    input  logic             ack_i,
    input  logic             eoi_stb_i,
    input  logic [2:0]       eoi_cmd_i,
    input  logic [LVL_W-1:0] eoi_level_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N_IRQ-1:0] irr_o,
    output logic [N_IRQ-1:0] isr_o
);
    typedef struct packed {
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
        logic [VEC_W-1:0] vec;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [N_IRQ-1:0] rise;
    logic             svc_found;
    logic [LVL_W-1:0] svc_idx;
    logic [N_IRQ-1:0] svc_onehot;
    logic [N_IRQ-1:0] allowed;
    logic [N_IRQ-1:0] eligible;
    logic             win_found;
    logic [LVL_W-1:0] win_idx;
    logic [N_IRQ-1:0] win_onehot;

    irq_edge_capture #(.W(N_IRQ)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (req_i),
        .rise_o (rise)
    );

    // Highest-priority entry currently in service
    irq_lowest_pick #(.W(N_IRQ), .IW(LVL_W)) u_svc_pick (
        .bits_i   (st_q.isr),
        .found_o  (svc_found),
        .idx_o    (svc_idx),
        .onehot_o (svc_onehot)
    );

    // Only inputs strictly above the top in-service entry may win
    assign allowed  = svc_found ? (svc_onehot - N_IRQ'(1)) : '1;
    assign eligible = st_q.irr & ~mask_i & allowed;

    irq_lowest_pick #(.W(N_IRQ), .IW(LVL_W)) u_win_pick (
        .bits_i   (eligible),
        .found_o  (win_found),
        .idx_o    (win_idx),
        .onehot_o (win_onehot)
    );

    logic             take;
    logic [N_IRQ-1:0] take_bit;
    logic [N_IRQ-1:0] eoi_clr;

    always_comb begin
        take     = ack_i && win_found;
        take_bit = take ? win_onehot : '0;

        eoi_clr = '0;
        if (eoi_stb_i) begin
            if (eoi_cmd_i == EOI_CMD_SPECIFIC)
                eoi_clr = N_IRQ'(1) << eoi_level_i;
            else if (eoi_cmd_i == EOI_CMD_LOWEST)
                eoi_clr = svc_onehot;
        end

        st_d     = st_q;
        st_d.irr = (st_q.irr & ~take_bit) | rise;
        st_d.isr = (st_q.isr & ~eoi_clr) | take_bit;
        if (take)
            st_d.vec = vec_base_i + VEC_W'(win_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = |(st_q.irr & ~mask_i);
    assign vec_o = st_q.vec;
    assign irr_o = st_q.irr;
    assign isr_o = st_q.isr;

    logic unused_idx;
    assign unused_idx = ^svc_idx;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk
    import irq_prio_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] req_i,
    input logic             ack_i,
    input logic             eoi_stb_i,
    input logic [2:0]       eoi_cmd_i,
    input logic [LVL_W-1:0] eoi_level_i,
    input logic [VEC_W-1:0] vec_o,
    input logic [N_IRQ-1:0] irr_o,
    input logic [N_IRQ-1:0] isr_o
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        // R1: a rising request line is latched
        a_r1_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_i[i]) |=> irr_o[i]);
        // R4: in-service bits appear only through an acknowledge
        a_r4_isr_set_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(isr_o[i]) |-> $past(ack_i));
        // R5/R6: in-service bits leave only through an end-of-interrupt
        a_r5_isr_cleared_by_eoi: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(isr_o[i]) |-> $past(eoi_stb_i));
    end

    a_r4_one_new_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> $countones(isr_o & ~$past(isr_o)) <= 1);

    a_r5_specific_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb_i && eoi_cmd_i == EOI_CMD_SPECIFIC && !ack_i)
        |=> !isr_o[$past(eoi_level_i)]);

    a_r6_lowest_only: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb_i && eoi_cmd_i == EOI_CMD_LOWEST && !ack_i && isr_o != '0)
        |=> $countones(isr_o) + 1 == $countones($past(isr_o)));

    a_r7_other_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb_i && eoi_cmd_i != EOI_CMD_SPECIFIC && eoi_cmd_i != EOI_CMD_LOWEST && !ack_i)
        |=> $stable(isr_o));

    a_r8_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(vec_o));
endmodule

bind irq_prio_core irq_prio_core_chk #(
    .N_IRQ(N_IRQ), .VEC_W(VEC_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
    .eoi_stb_i(eoi_stb_i), .eoi_cmd_i(eoi_cmd_i), .eoi_level_i(eoi_level_i),
    .vec_o(vec_o), .irr_o(irr_o), .isr_o(isr_o)
);

// File: tb/irq_prio_core_bench.sv
module irq_prio_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, base = '0;
    logic       ack = 1'b0, stb = 1'b0;
    logic [2:0] cmd = '0, lvl = '0;
    logic       irq;
    logic [7:0] vec, irr, isr;

    int total = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0] m_irr = '0, m_isr = '0, m_vec = '0, m_prev = '0;

    always #5 clk = ~clk;

    irq_prio_core u_irq_prio_core (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .vec_base_i(base),
        .ack_i(ack), .eoi_stb_i(stb), .eoi_cmd_i(cmd), .eoi_level_i(lvl),
        .irq_o(irq), .vec_o(vec), .irr_o(irr), .isr_o(isr)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    // One clock with the given inputs; model updated from the requirements
    task automatic step(logic [7:0] r, logic [7:0] m, logic [7:0] b, logic a,
                        logic s, logic [2:0] c, logic [2:0] l, string tag);
        logic [7:0] rise, pend, win_bit, clr;
        int top, win;
        req = r; mask = m; base = b; ack = a; stb = s; cmd = c; lvl = l;
        rise = r & ~m_prev;
        pend = m_irr & ~m;
        top  = lowest(m_isr);                   // R3
        win  = -1;
        for (int i = 0; i < 8; i++)
            if (win < 0 && i < top && pend[i]) win = i;
        win_bit = (a && win >= 0) ? 8'(1 << win) : 8'h00;
        clr = 8'h00;
        if (s && c == 3'b101) clr = 8'(1 << l);                       // R5
        else if (s && c == 3'b100 && m_isr != 0) clr = 8'(1 << lowest(m_isr)); // R6
        @(posedge clk);
        #1;
        m_irr = (m_irr & ~win_bit) | rise;       // R1, R10
        m_isr = (m_isr & ~clr) | win_bit;        // R4, R10
        if (a && win >= 0) m_vec = b + 8'(win);  // R4, R8
        m_prev = r;
        chk({tag, " R1 irr"}, irr, m_irr);
        chk({tag, " R4 isr"}, isr, m_isr);
        chk({tag, " R8 vec"}, vec, m_vec);
        chk({tag, " R2 irq"}, {7'd0, irq}, {7'd0, |(m_irr & ~m)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 irr reset", irr, 8'h00);
        chk("R9 isr reset", isr, 8'h00);
        chk("R9 vec reset", vec, 8'h00);
        chk("R9 irq reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        // Directed corner cases, base 0x20, all unmasked
        step(8'h08, 8'h00, 8'h20, 0, 0, 3'd0, 3'd0, "d1");
        chk("R1 edge latched", irr, 8'h08);
        step(8'h08, 8'h00, 8'h20, 1, 0, 3'd0, 3'd0, "d2");
        chk("R4 vector base+3", vec, 8'h23);
        chk("R4 moved to isr", isr, 8'h08);
        step(8'h08, 8'h00, 8'h20, 0, 0, 3'd0, 3'd0, "d3");
        chk("R1 held line once", irr, 8'h00);
        step(8'h28, 8'h00, 8'h20, 0, 0, 3'd0, 3'd0, "d4");
        step(8'h28, 8'h00, 8'h20, 1, 0, 3'd0, 3'd0, "d5");
        chk("R3 lower prio blocked", isr, 8'h08);
        chk("R8 vec held on no winner", vec, 8'h23);
        step(8'h2A, 8'h00, 8'h20, 0, 0, 3'd0, 3'd0, "d6");
        step(8'h2A, 8'h00, 8'h20, 1, 0, 3'd0, 3'd0, "d7");
        chk("R3 higher prio nests", vec, 8'h21);
        chk("R3 nested isr", isr, 8'h0A);
        step(8'h2A, 8'h20, 8'h20, 0, 1, 3'b111, 3'd1, "d8");
        chk("R2 masked irq low", {7'd0, irq}, 8'h00);
        chk("R7 cmd 111 ignored", isr, 8'h0A);
        step(8'h2A, 8'h20, 8'h20, 0, 1, 3'b001, 3'd1, "d9");
        chk("R7 cmd 001 ignored", isr, 8'h0A);
        step(8'h2A, 8'h20, 8'h20, 0, 1, 3'b100, 3'd0, "d10");
        chk("R6 lowest cleared", isr, 8'h08);
        step(8'h2A, 8'h00, 8'h20, 0, 1, 3'b101, 3'd3, "d11");
        chk("R5 specific cleared", isr, 8'h00);
        step(8'h2A, 8'h00, 8'hFC, 1, 1, 3'b100, 3'd0, "d12");
        chk("R4 vector wraps", vec, 8'h01);
        chk("R10 ack with eoi", isr, 8'h20);
        step(8'h00, 8'h00, 8'h20, 0, 0, 3'd0, 3'd0, "d13");

        // Constrained random traffic
        for (int n = 0; n < 2000; n++) begin
            logic [7:0] r, m;
            logic a, s;
            logic [2:0] c;
            r = req ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            m = (($urandom % 8) == 0) ? 8'($urandom) & 8'($urandom) : mask;
            a = ($urandom % 3) == 0;
            s = ($urandom % 4) == 0;
            c = (($urandom % 2) == 0) ? ((($urandom % 2) == 0) ? 3'b101 : 3'b100)
                                      : 3'($urandom);
            step(r, m, 8'($urandom), a, s, c, 3'($urandom), "rnd");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule